// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This engine carries out maintenance work on a physically tagged, unified second-level cache. Software drives it through a small command port. A "start" command records the first address of a range. A later "end" command supplies the inclusive last address and picks the operation: clean or invalidate. The engine then visits each 32-byte line whose first byte lies between the two addresses, bounds included. For every line it raises one request on a request/acknowledge port that stands in for the tag and data machinery. The port carries a line-aligned address and an operation code. The stall output stays high for the whole walk.

The port also takes single-line commands: clean, invalidate, or clean plus invalidate of one line. Each of these costs exactly one handshake. Only the start of a range is translated upstream, so both ends must lie in one 4 KiB page. The engine refuses a range that crosses a page and raises an error flag. A range whose last line lies below its first line completes at once and touches nothing.

Top module: `l2_range_engine`

## Requirements
- R1: Command code 0 records the line of `cmd_addr` as the range start and arms the engine. Code 1 (range clean) or code 2 (range invalidate) starts a walk only while the engine is armed. An end command seen while unarmed has no effect.
- R2: An armed, valid range issues each line from the start line to the end line exactly once, in ascending order, with the address stepping by 32. `req_op` is 0 for clean and 1 for invalidate.
- R3: Bits [4:0] of `cmd_addr` are ignored. Every `req_addr` has bits [4:0] equal to zero.
- R4: `stall` rises in the cycle after an accepted trigger that issues lines. It falls in the cycle after the acknowledge of the last line. `req_valid` is high exactly while `stall` is high.
- R5: While `req_valid` is high and `req_ack` is low, `req_addr` and `req_op` hold their values.
- R6: An end command whose address differs from the start address in any bit above bit 11 is rejected. A rejection sets `err`, issues no request and leaves `stall` low. `err` clears on the next accepted command.
- R7: If the end line is below the start line, no request is issued, `stall` stays low and `err` stays low.
- R8: Codes 3 (clean), 4 (invalidate) and 5 (clean plus invalidate) each issue one request for the line of `cmd_addr`. The `req_op` values are 0, 1 and 2 respectively. Each stalls only until that request is acknowledged.
- R9: A command presented while `stall` is high is ignored. It changes neither the recorded start nor the armed state.
- R10: An end command consumes the arming, whether it is valid, rejected or empty. A second end command without a new start command has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command: 0 start, 1 range clean, 2 range invalidate, 3/4/5 single line clean/invalidate/clean+invalidate |
| cmd_addr | input | AW | Byte address carried by the command |
| stall | output | 1 | Requester hold while work is outstanding |
| err | output | 1 | Last end command was rejected for crossing a page |
| req_valid | output | 1 | Line operation request |
| req_addr | output | AW | Line-aligned address of the request |
| req_op | output | 2 | 0 clean, 1 invalidate, 2 clean+invalidate |
| req_ack | input | 1 | Line operation completed |

## Verification
Random ranges within a page are driven with random byte offsets and random acknowledge delays. They show whether the walk covers both inclusive bounds, ignores the low address bits and holds each request until it is accepted. The directed cases are:
- a full 128-line page, which exposes off-by-one errors at the page edge;
- a one-line range, which separates inclusive from exclusive end handling;
- an inverted range and a cross-page range, which separate the empty case from the rejected case;
- an end command with no start and a command issued during a walk, which show whether arming is consumed and whether commands are ignored while busy.

// File: rtl/l2rm_pkg.sv
package l2rm_pkg;
  typedef enum logic [2:0] {
    CMD_START      = 3'd0,
    CMD_END_CLEAN  = 3'd1,
    CMD_END_INV    = 3'd2,
    CMD_LINE_CLEAN = 3'd3,
    CMD_LINE_INV   = 3'd4,
    CMD_LINE_CINV  = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    OP_CLEAN = 2'd0,
    OP_INV   = 2'd1,
    OP_CINV  = 2'd2
  } op_e;
endpackage

// File: rtl/l2rm_cmd_decode.sv
module l2rm_cmd_decode
  import l2rm_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LINE_BITS = 5,
  parameter int PAGE_BITS = 12,
  localparam int LW       = AW - LINE_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  input  logic [AW-1:0] cmd_addr,
  input  logic          busy,
  output logic          go,
  output logic [LW-1:0] go_first,
  output logic [LW-1:0] go_last,
  output logic [1:0]    go_op,
  output logic          err
);
  localparam int PG_LO = PAGE_BITS - LINE_BITS;

  logic [LW-1:0] start_q;
  logic          armed_q;
  logic          accept, is_end, page_ok;
  logic [LW-1:0] in_line;

  always_comb begin
    accept   = cmd_valid && !busy;
    in_line  = cmd_addr[AW-1:LINE_BITS];
    is_end   = (cmd_code == CMD_END_CLEAN) || (cmd_code == CMD_END_INV);
    page_ok  = (start_q[LW-1:PG_LO] == in_line[LW-1:PG_LO]);
    go       = 1'b0;
    go_first = in_line;
    go_last  = in_line;
    go_op    = OP_CLEAN;
    if (accept) begin
      case (cmd_code)
        CMD_END_CLEAN, CMD_END_INV: begin
          go_first = start_q;
          go_op    = (cmd_code == CMD_END_CLEAN) ? OP_CLEAN : OP_INV;
          go       = armed_q && page_ok && (in_line >= start_q);
        end
        CMD_LINE_CLEAN: begin go = 1'b1; go_op = OP_CLEAN; end
        CMD_LINE_INV:   begin go = 1'b1; go_op = OP_INV;   end
        CMD_LINE_CINV:  begin go = 1'b1; go_op = OP_CINV;  end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      armed_q <= 1'b0;
      err     <= 1'b0;
    end else if (accept) begin
      err <= 1'b0;
      if (cmd_code == CMD_START) begin
        start_q <= in_line;
        armed_q <= 1'b1;
      end else if (is_end) begin
        armed_q <= 1'b0;
        err     <= armed_q && !page_ok;
      end
    end
  end

  // R9: a busy engine leaves the decode state untouched
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(start_q) && $stable(armed_q) && $stable(err));
  // R6: a rejection is only possible from the armed state
  p_reject_armed_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(armed_q));
  // R10: after any end command the engine is disarmed
  p_disarm_r10: assert property (@(posedge clk) disable iff (rst)
    accept && is_end |=> !armed_q);
endmodule

// File: rtl/l2rm_walker.sv
module l2rm_walker
#(
  parameter int LW    = 27,
  parameter int PG_LO = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [LW-1:0] first,
  input  logic [LW-1:0] last,
  input  logic [1:0]    op,
  input  logic          ack,
  output logic          busy,
  output logic [LW-1:0] cur,
  output logic [1:0]    cur_op
);
  logic [LW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cur    <= '0;
      last_q <= '0;
      cur_op <= '0;
    end else if (!busy) begin
      if (go) begin
        busy   <= 1'b1;
        cur    <= first;
        last_q <= last;
        cur_op <= op;
      end
    end else if (ack) begin
      if (cur == last_q) busy <= 1'b0;
      else               cur  <= cur + 1'b1;
    end
  end

  // R5: request held until acknowledged
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    busy && !ack |=> busy && $stable(cur) && $stable(cur_op));
  // R2: ascending step of one line
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    busy && ack && (cur != last_q) |=> busy && (cur == $past(cur) + 1'b1));
  // R4: walk ends right after the last acknowledge
  p_end_r4: assert property (@(posedge clk) disable iff (rst)
    busy && ack && (cur == last_q) |=> !busy);
  // R6: a walk never leaves its page
  p_page_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> cur[LW-1:PG_LO] == last_q[LW-1:PG_LO]);
  // R9: no trigger is produced while busy
  p_no_go_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !go);
endmodule

// File: rtl/l2_range_engine.sv
module l2_range_engine
  import l2rm_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LINE_BITS = 5,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  input  logic [AW-1:0] cmd_addr,
  output logic          stall,
  output logic          err,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic [1:0]    req_op,
  input  logic          req_ack
);
  localparam int LW = AW - LINE_BITS;

  logic          busy, go;
  logic [LW-1:0] go_first, go_last, cur;
  logic [1:0]    go_op, cur_op;

  l2rm_cmd_decode #(.AW(AW), .LINE_BITS(LINE_BITS), .PAGE_BITS(PAGE_BITS)) u_dec (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .busy(busy), .go(go), .go_first(go_first),
    .go_last(go_last), .go_op(go_op), .err(err)
  );

  l2rm_walker #(.LW(LW), .PG_LO(PAGE_BITS - LINE_BITS)) u_walk (
    .clk(clk), .rst(rst), .go(go), .first(go_first), .last(go_last),
    .op(go_op), .ack(req_ack), .busy(busy), .cur(cur), .cur_op(cur_op)
  );

  assign stall     = busy;
  assign req_valid = busy;
  assign req_addr  = {cur, {LINE_BITS{1'b0}}};
  assign req_op    = cur_op;

  // R6: a rejected range never coincides with a stall
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> !stall && !req_valid);
endmodule

// File: tb/test_l2_range_engine.sv
module test_l2_range_engine;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_code = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic          stall, err, req_valid;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_op;
  logic          req_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  l2_range_engine i_l2_range_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .stall(stall), .err(err), .req_valid(req_valid),
    .req_addr(req_addr), .req_op(req_op), .req_ack(req_ack)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] code, input logic [AW-1:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // drains an active walk, checking each line; starts at a negedge
  task automatic drain(input longint first_line, input int n, input int op);
    int cnt = 0;
    int guard = 0;
    bit mis = 0;
    chk(stall == 1'b1, "R4 stall after trigger", stall, 1);
    while (stall && guard < 5000) begin
      guard++;
      if (!req_valid || req_addr != AW'((first_line + cnt) << 5) ||
          req_op != 2'(op) || req_addr[4:0] != 0) begin
        if (!mis) chk(1'b0, "R2/R3/R4 request line", req_addr, (first_line + cnt) << 5);
        mis = 1;
      end
      req_ack = ($urandom % 3) != 0;
      @(negedge clk);
      if (req_ack) cnt++;
      req_ack = 1'b0;
    end
    chk(cnt == n, "R2 line count", cnt, n);
    chk(!stall && !req_valid, "R4 stall drops after last ack", stall, 0);
  endtask

  task automatic do_range(input logic [2:0] code, input logic [AW-1:0] s, input logic [AW-1:0] e);
    longint sl = s >> 5;
    longint el = e >> 5;
    bit same = (s[AW-1:12] == e[AW-1:12]);
    send(3'd0, s);
    send(code, e);
    if (!same) begin
      chk(err && !stall && !req_valid, "R6 cross page rejected", {err, stall, req_valid}, 3'b100);
    end else if (el < sl) begin
      chk(!err && !stall && !req_valid, "R7 empty range", {err, stall, req_valid}, 0);
    end else begin
      chk(!err, "R6 no err on valid range", err, 0);
      drain(sl, int'(el - sl + 1), code == 3'd1 ? 0 : 1);
    end
  endtask

  task automatic do_line(input logic [2:0] code, input logic [AW-1:0] a);
    send(code, a);
    drain(a >> 5, 1, int'(code) - 3);
  endtask

  task automatic quiet(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk(!stall && !req_valid, tag, stall, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!stall && !err && !req_valid, "reset state", {stall, err, req_valid}, 0);

    // R1: end without prior start does nothing
    send(3'd1, 32'h0000_0040);
    quiet("R1 end without start");

    // R2 full page, R3 low bits ignored
    do_range(3'd1, 32'h0000_1000, 32'h0000_1FFF);
    do_range(3'd2, 32'h0000_2013, 32'h0000_207F);
    // single-line range: inclusive bound
    do_range(3'd2, 32'h0000_3040, 32'h0000_3040);
    // R7 inverted range
    do_range(3'd1, 32'h0000_4100, 32'h0000_40E0);
    // R6 cross page, then clear on next command
    do_range(3'd2, 32'h0000_5FE0, 32'h0000_6000);
    // R10: second end after rejection
    send(3'd2, 32'h0000_5FE0);
    quiet("R10 arming consumed");
    send(3'd0, 32'h0000_7000);
    chk(!err, "R6 err cleared by next command", err, 0);

    // R8 single line ops
    do_line(3'd3, 32'h0000_8011);
    do_line(3'd4, 32'h0000_8120);
    do_line(3'd5, 32'h0000_81FF);

    // R9: command during a walk is ignored
    send(3'd0, 32'h0000_A000);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 3'd1; cmd_addr = 32'h0000_A060;
    @(negedge clk);
    cmd_code = 3'd0; cmd_addr = 32'h0000_9000;
    @(negedge clk);
    cmd_valid = 1'b0;
    drain(32'h0000_A000 >> 5, 4, 0);
    send(3'd2, 32'h0000_9020);
    quiet("R9 busy start ignored / R10");

    // random ranges
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] s, e;
      s = $urandom & 32'h00FF_FFFF;
      case ($urandom % 6)
        0: e = s + 32'h1000;
        1: e = s - ($urandom % 96);
        default: e = {s[AW-1:12], 12'h000} | (($urandom % 2) ? (s[11:0] + 12'($urandom % 640))
                                                                : 12'($urandom));
      endcase
      if ($urandom % 2) do_range(3'd1, s, e);
      else              do_range(3'd2, s, e);
      if (k % 10 == 0) do_line(3'(3 + ($urandom % 3)), $urandom);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule